// File: doc/BRIEF.md
# Double-Precision Operand Classifier and NaN Quieter

This block looks at one 64-bit binary floating-point operand each clock and reports which of six categories it falls into: zero, subnormal, normal, infinity, quiet NaN or signaling NaN. When the operand is a signaling NaN, the block also produces a quiet NaN from it and raises an invalid-operation flag. All other operands pass through to the result output unchanged.

The meaning of the top fraction bit depends on a convention input. Under the newer convention, a set top fraction bit marks a quiet NaN. Under the legacy convention, a set top fraction bit marks a signaling NaN. In legacy mode, quieting clears that bit. If this would leave the fraction empty and turn the value into an infinity, the next fraction bit down is set so that the result is still a NaN. All outputs are registered, so they appear one clock after the operand is presented.

Top module: `fp64_classq`

## Requirements
- R1: An operand with exponent field (bits 62:52) zero and fraction field (bits 51:0) zero gives class code 0, whatever the sign bit (bit 63).
- R2: An operand with exponent zero and a nonzero fraction gives class code 1.
- R3: An operand whose exponent is neither all zeros nor all ones gives class code 2.
- R4: An operand with exponent all ones (0x7FF) and a zero fraction gives class code 3, for either sign and either convention.
- R5: An operand with exponent all ones and a nonzero fraction is a NaN. It is signaling (class code 5) when `ieee2008_i` XOR fraction bit 51 equals 1; otherwise it is quiet (class code 4).
- R6: With `ieee2008_i` = 1, a signaling NaN gives a result equal to the operand with bit 51 set, and `invalid_o` = 1.
- R7: With `ieee2008_i` = 0, a signaling NaN gives a result equal to the operand with bit 51 cleared, and `invalid_o` = 1.
- R8: With `ieee2008_i` = 0, if clearing bit 51 leaves fraction bits 50:0 all zero, the result also has bit 50 set. Bit 50 is otherwise left as it was.
- R9: Any operand that is not a signaling NaN appears unchanged on `res_o`, with `invalid_o` = 0.
- R10: Outputs change one clock edge after the operand and convention are presented. While `rst_n` is low, `class_o`, `res_o` and `invalid_o` are all zero.
- R11: Quieting never changes the sign bit or the exponent field, and the quieted result is always a NaN.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_i | input | 64 | Operand: sign 63, exponent 62:52, fraction 51:0 |
| ieee2008_i | input | 1 | 1 selects the newer quiet-bit convention, 0 the legacy one |
| class_o | output | 3 | Class code: 0 zero, 1 subnormal, 2 normal, 3 infinity, 4 quiet NaN, 5 signaling NaN |
| res_o | output | 64 | Operand, or its quieted form if it was a signaling NaN |
| invalid_o | output | 1 | High when the registered operand was a signaling NaN |

## Verification
The clocked properties assume that `op_i` and `ieee2008_i` hold known values and stay steady across every capturing edge while `rst_n` is high. They also assume that reset is released away from a clock edge. The stimulus meets these assumptions by changing every input only on the falling edge and sampling outputs on the next falling edge. The operand set covers both signs, each category, and both conventions for the same NaN bit patterns. It also includes the legacy pattern whose fraction would otherwise become empty.

// File: rtl/fp64_classq.sv
module fp64_classq #(
  parameter int EXP_W  = 11,
  parameter int FRAC_W = 52
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [EXP_W+FRAC_W:0]     op_i,
  input  logic                      ieee2008_i,
  output logic [2:0]                class_o,
  output logic [EXP_W+FRAC_W:0]     res_o,
  output logic                      invalid_o
);
  localparam int W = EXP_W + FRAC_W + 1;
  localparam logic [2:0] C_ZERO = 3'd0, C_SUB = 3'd1, C_NORM = 3'd2,
                         C_INF = 3'd3, C_QNAN = 3'd4, C_SNAN = 3'd5;

  logic [EXP_W-1:0]  exp_f;
  logic [FRAC_W-1:0] frac_f, frac_clr, frac_q;
  logic              exp_ones, exp_zero, frac_nz, is_nan, is_snan;
  logic [2:0]        class_d;

  assign exp_f    = op_i[FRAC_W +: EXP_W];
  assign frac_f   = op_i[FRAC_W-1:0];
  assign exp_ones = &exp_f;
  assign exp_zero = ~|exp_f;
  assign frac_nz  = |frac_f;
  assign is_nan   = exp_ones & frac_nz;
  assign is_snan  = is_nan & (ieee2008_i ^ frac_f[FRAC_W-1]);

  assign frac_clr = {1'b0, frac_f[FRAC_W-2:0]};

  always_comb begin
    if (ieee2008_i)
      frac_q = frac_f | {1'b1, {(FRAC_W-1){1'b0}}};
    else if (frac_clr == '0)
      frac_q = {2'b01, {(FRAC_W-2){1'b0}}};
    else
      frac_q = frac_clr;
  end

  always_comb begin
    if (exp_zero)      class_d = frac_nz ? C_SUB : C_ZERO;
    else if (!exp_ones) class_d = C_NORM;
    else if (!frac_nz)  class_d = C_INF;
    else               class_d = is_snan ? C_SNAN : C_QNAN;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      class_o   <= C_ZERO;
      res_o     <= '0;
      invalid_o <= 1'b0;
    end else begin
      class_o   <= class_d;
      res_o     <= is_snan ? {op_i[W-1:FRAC_W], frac_q} : op_i;
      invalid_o <= is_snan;
    end
  end
endmodule

module fp64_classq_chk #(
  parameter int EXP_W  = 11,
  parameter int FRAC_W = 52
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic [EXP_W+FRAC_W:0] op_i,
  input logic                  ieee2008_i,
  input logic [2:0]            class_o,
  input logic [EXP_W+FRAC_W:0] res_o,
  input logic                  invalid_o
);
  logic in_nan, in_snan;
  assign in_nan  = (&op_i[FRAC_W +: EXP_W]) && (|op_i[FRAC_W-1:0]);
  assign in_snan = in_nan && (ieee2008_i ^ op_i[FRAC_W-1]);

  a_r5_code_range: assert property (@(posedge clk) disable iff (!rst_n)
    class_o <= 3'd5);

  a_r5_flag_matches_class: assert property (@(posedge clk) disable iff (!rst_n)
    invalid_o == (class_o == 3'd5));

  a_r6_new_sets_top: assert property (@(posedge clk) disable iff (!rst_n)
    (in_snan && ieee2008_i) |=> (invalid_o && res_o[FRAC_W-1]));

  a_r7_legacy_clears_top: assert property (@(posedge clk) disable iff (!rst_n)
    (in_snan && !ieee2008_i) |=> (invalid_o && !res_o[FRAC_W-1]));

  a_r9_passthrough: assert property (@(posedge clk) disable iff (!rst_n)
    !in_snan |=> (!invalid_o && res_o == $past(op_i)));

  a_r11_sign_exp_kept: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (res_o[EXP_W+FRAC_W:FRAC_W] == $past(op_i[EXP_W+FRAC_W:FRAC_W])));

  a_r11_still_nan: assert property (@(posedge clk) disable iff (!rst_n)
    invalid_o |-> ((&res_o[FRAC_W +: EXP_W]) && (|res_o[FRAC_W-1:0])));
endmodule

bind fp64_classq fp64_classq_chk #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .op_i(op_i), .ieee2008_i(ieee2008_i),
  .class_o(class_o), .res_o(res_o), .invalid_o(invalid_o)
);

// File: tb/sim_fp64_classq.sv
module sim_fp64_classq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] op_i = '0;
  logic        ieee2008_i = 1'b1;
  logic [2:0]  class_o;
  logic [63:0] res_o;
  logic        invalid_o;
  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  fp64_classq u0 (
    .clk(clk), .rst_n(rst_n), .op_i(op_i), .ieee2008_i(ieee2008_i),
    .class_o(class_o), .res_o(res_o), .invalid_o(invalid_o)
  );

  task automatic expect_out(string tag, logic [2:0] c, logic [63:0] r, logic v);
    n_chk++;
    if (class_o !== c || res_o !== r || invalid_o !== v) begin
      n_bad++;
      $display("FAIL %s: got class=%0d res=%h inv=%b, expected class=%0d res=%h inv=%b",
               tag, class_o, res_o, invalid_o, c, r, v);
    end
  endtask

  task automatic apply(string tag, logic [63:0] op, logic m,
                       logic [2:0] c, logic [63:0] r, logic v);
    @(negedge clk);
    op_i = op;
    ieee2008_i = m;
    @(negedge clk);
    expect_out(tag, c, r, v);
  endtask

  task automatic t_reset;
    @(negedge clk);
    expect_out("R10 reset state", 3'd0, 64'h0, 1'b0);
    rst_n = 1'b1;
    apply("R10 one-cycle latency", 64'h3FF0000000000000, 1'b1, 3'd2, 64'h3FF0000000000000, 1'b0);
    apply("R10 snan prior to reset", 64'h7FF0000000000001, 1'b1, 3'd5, 64'h7FF8000000000001, 1'b1);
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    expect_out("R10 reset mid-run", 3'd0, 64'h0, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic t_zero;
    apply("R1 positive zero", 64'h0000000000000000, 1'b1, 3'd0, 64'h0000000000000000, 1'b0);
    apply("R1 negative zero", 64'h8000000000000000, 1'b0, 3'd0, 64'h8000000000000000, 1'b0);
  endtask

  task automatic t_subnormal;
    apply("R2 smallest subnormal", 64'h0000000000000001, 1'b1, 3'd1, 64'h0000000000000001, 1'b0);
    apply("R2 negative subnormal", 64'h800FFFFFFFFFFFFF, 1'b0, 3'd1, 64'h800FFFFFFFFFFFFF, 1'b0);
  endtask

  task automatic t_normal;
    apply("R3 one", 64'h3FF0000000000000, 1'b1, 3'd2, 64'h3FF0000000000000, 1'b0);
    apply("R3 largest finite", 64'hFFEFFFFFFFFFFFFF, 1'b0, 3'd2, 64'hFFEFFFFFFFFFFFFF, 1'b0);
    apply("R3 smallest normal", 64'h0010000000000000, 1'b1, 3'd2, 64'h0010000000000000, 1'b0);
  endtask

  task automatic t_inf;
    apply("R4 +inf new", 64'h7FF0000000000000, 1'b1, 3'd3, 64'h7FF0000000000000, 1'b0);
    apply("R4 -inf legacy", 64'hFFF0000000000000, 1'b0, 3'd3, 64'hFFF0000000000000, 1'b0);
  endtask

  task automatic t_new_mode;
    apply("R5 R9 new quiet", 64'h7FF8000000000000, 1'b1, 3'd4, 64'h7FF8000000000000, 1'b0);
    apply("R6 R11 new signaling neg", 64'hFFF0000000000001, 1'b1, 3'd5, 64'hFFF8000000000001, 1'b1);
    apply("R6 new signaling wide", 64'h7FF7FFFFFFFFFFFF, 1'b1, 3'd5, 64'h7FFFFFFFFFFFFFFF, 1'b1);
  endtask

  task automatic t_legacy_mode;
    apply("R5 R9 legacy quiet", 64'h7FF0000000000001, 1'b0, 3'd4, 64'h7FF0000000000001, 1'b0);
    apply("R5 legacy same bits as new quiet", 64'h7FF8000000000000, 1'b0, 3'd5, 64'h7FF4000000000000, 1'b1);
    apply("R7 legacy signaling", 64'h7FF8000000000005, 1'b0, 3'd5, 64'h7FF0000000000005, 1'b1);
    apply("R8 legacy bit50 already set", 64'h7FFC000000000000, 1'b0, 3'd5, 64'h7FF4000000000000, 1'b1);
  endtask

  task automatic t_collapse;
    apply("R8 R11 legacy empty remainder neg", 64'hFFF8000000000000, 1'b0, 3'd5, 64'hFFF4000000000000, 1'b1);
    apply("R8 legacy low bit only", 64'h7FF8000000000001, 1'b0, 3'd5, 64'h7FF0000000000001, 1'b1);
  endtask

  initial begin
    t_reset();
    t_zero();
    t_subnormal();
    t_normal();
    t_inf();
    t_new_mode();
    t_legacy_mode();
    t_collapse();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule